// File: doc/BRIEF.md
# SPI register-access slave

This block lets an external SPI master read and write a small bank of 8-bit registers that live elsewhere in the chip. A transfer opens when chip select falls. The serial clock idles high, the master changes data on each falling clock edge, and both sides capture on the rising edge. The first byte is a command byte. Its first bit on the wire chooses read or write, its second bit chooses whether the register address advances between data bytes, and its last six bits give the starting register address. One or more data bytes follow, most significant bit first, for as long as chip select stays low.

On the register side the block issues single-cycle strobes. A write strobe carries the address and the received byte. A read strobe asks for a byte, which is expected on the read-data input one cycle later. Read data can leave on a dedicated output pin (four-wire mode) or on the shared bidirectional data pin (three-wire mode). A mode input, fed by a configuration register elsewhere, chooses between them. Output enables for both pins are produced here. Chip select, serial clock and serial input are each brought into the system clock through a two-flop synchroniser, and the clock edges are detected in the system domain.

Top module: `spi_regslave`

## Requirements
- R1: While reset is held and afterwards with chip select high, both output enables and both register strobes are low.
- R2: The command byte is decoded as follows, in wire order: first bit 1 means read and 0 means write, second bit 1 means auto-increment, and the remaining six bits are the register address, most significant bit first.
- R3: A single write takes 16 clocks. After the 16th rising edge, one write strobe pulses with the command address and the received data byte.
- R4: In a write of several bytes, each byte gives one write strobe. The address advances by one per byte and wraps from 63 to 0 when the increment bit is 1, and stays fixed when it is 0.
- R5: On a read, a read strobe with the command address pulses after the 8th rising edge. The byte returned on the read-data input one cycle later is driven out most significant bit first, starting at the falling edge that opens bit 8, and the master captures it on the following rising edges.
- R6: A read of N bytes issues N+1 read strobes: one after the command byte and one after each data byte, the last one a prefetch. The addresses follow the R4 increment rule, so the master receives consecutive registers or the same register repeated.
- R7: With the mode input at 0, read data leaves on the dedicated output pin with its enable high, and the shared pin enable stays low.
- R8: With the mode input at 1, read data leaves on the shared pin with its enable high, the dedicated pin enable stays low, and reads of several bytes work.
- R9: Both output enables are low during the command byte, during write data, and within five system cycles after chip select rises.
- R10: If chip select rises before a byte is complete, that partial byte causes no strobe, and the next transfer decodes a fresh command byte.
- R11: A read strobe and a write strobe are never high together, and each lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_csn | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock, idles high |
| spi_sdio_i | input | 1 | Shared data pin, input side |
| spi_sdio_o | output | 1 | Shared data pin, output value |
| spi_sdio_oe | output | 1 | Shared data pin output enable (three-wire read) |
| spi_sdo_o | output | 1 | Dedicated output pin value |
| spi_sdo_oe | output | 1 | Dedicated output pin enable (four-wire read) |
| three_wire | input | 1 | 0 selects the dedicated output pin, 1 the shared pin |
| reg_rd_stb | output | 1 | One-cycle register read request |
| reg_wr_stb | output | 1 | One-cycle register write request |
| reg_addr | output | ADDR_W | Register address for either strobe |
| reg_wdata | output | DATA_W | Byte to write |
| reg_rdata | input | DATA_W | Read byte, valid the cycle after the read strobe |

## Verification
The assertions assume that a byte spans several system cycles, so that strobes cannot come back to back, and that the register side answers a read strobe exactly one cycle later. They also assume that the mode input only changes while chip select is high. The bench keeps the serial clock half period at 8 system cycles, which leaves room for the read turnaround before the falling edge that opens each outgoing byte. It changes the mode only between frames and resolves the shared pin so that the slave's value wins whenever its enable is high.

// File: rtl/spi_regslave_pkg.sv
package spi_regslave_pkg;
  localparam int DEF_ADDR_W = 6;
  localparam int DEF_DATA_W = 8;
  localparam int DEF_SYNC_STAGES = 2;

  typedef enum logic {
    PH_CMD  = 1'b0,
    PH_DATA = 1'b1
  } phase_t;
endpackage

// File: rtl/spi_sync_edge.sv
module spi_sync_edge #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= INIT;
    end else begin
      for (int i = STAGES - 1; i > 0; i--) stg[i] <= stg[i-1];
      stg[0] <= din;
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/spi_bit_engine.sv
module spi_bit_engine #(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              rise,
  input  logic              din,
  output logic              byte_done,
  output logic [DATA_W-1:0] byte_val,
  output logic [CNT_W-1:0]  bit_idx
);
  logic [DATA_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg     <= '0;
      cnt       <= '0;
      byte_done <= 1'b0;
    end else if (!active) begin
      cnt       <= '0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (rise) begin
        shreg <= {shreg[DATA_W-2:0], din};
        if (cnt == CNT_W'(DATA_W - 1)) begin
          cnt       <= '0;
          byte_done <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign byte_val = shreg;
  assign bit_idx  = cnt;
endmodule

// File: rtl/spi_txn_ctrl.sv
module spi_txn_ctrl
  import spi_regslave_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              fall,
  input  logic              byte_done,
  input  logic [DATA_W-1:0] byte_val,
  input  logic [CNT_W-1:0]  bit_idx,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              rd_stb,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              tx_bit,
  output logic              drive
);
  phase_t            phase;
  logic              rw_q;
  logic              inc_q;
  logic              load_pend;
  logic [ADDR_W-1:0] cur_addr;
  logic [ADDR_W-1:0] step_addr;
  logic [DATA_W-1:0] tx_byte;
  logic [CNT_W-1:0]  out_sel;

  assign step_addr = cur_addr + ADDR_W'(inc_q);
  assign out_sel   = CNT_W'(DATA_W - 1) - bit_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_CMD;
      rw_q      <= 1'b0;
      inc_q     <= 1'b0;
      load_pend <= 1'b0;
      cur_addr  <= '0;
      tx_byte   <= '0;
      tx_bit    <= 1'b0;
      drive     <= 1'b0;
      rd_stb    <= 1'b0;
      wr_stb    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
    end else begin
      rd_stb    <= 1'b0;
      wr_stb    <= 1'b0;
      load_pend <= rd_stb;
      if (load_pend) tx_byte <= reg_rdata;
      if (!active) begin
        phase <= PH_CMD;
        drive <= 1'b0;
      end else begin
        if (fall) begin
          tx_bit <= tx_byte[out_sel];
          if (phase == PH_DATA && rw_q) drive <= 1'b1;
        end
        if (byte_done) begin
          if (phase == PH_CMD) begin
            phase    <= PH_DATA;
            rw_q     <= byte_val[DATA_W-1];
            inc_q    <= byte_val[DATA_W-2];
            cur_addr <= byte_val[ADDR_W-1:0];
            if (byte_val[DATA_W-1]) begin
              rd_stb   <= 1'b1;
              reg_addr <= byte_val[ADDR_W-1:0];
            end
          end else if (rw_q) begin
            cur_addr <= step_addr;
            rd_stb   <= 1'b1;
            reg_addr <= step_addr;
          end else begin
            cur_addr  <= step_addr;
            wr_stb    <= 1'b1;
            reg_addr  <= cur_addr;
            reg_wdata <= byte_val;
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_regslave.sv
module spi_regslave
  import spi_regslave_pkg::*;
#(
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int DATA_W = DEF_DATA_W,
  parameter int SYNC_STAGES = DEF_SYNC_STAGES,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_csn,
  input  logic              spi_sck,
  input  logic              spi_sdio_i,
  output logic              spi_sdio_o,
  output logic              spi_sdio_oe,
  output logic              spi_sdo_o,
  output logic              spi_sdo_oe,
  input  logic              three_wire,
  output logic              reg_rd_stb,
  output logic              reg_wr_stb,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] reg_rdata
);
  logic [2:0]        pins_s;
  logic              csn_s, sck_s, sdi_s, sck_prev;
  logic              active, rise, fall;
  logic              byte_done;
  logic [DATA_W-1:0] byte_val;
  logic [CNT_W-1:0]  bit_idx;
  logic              tx_bit, drive;
  logic              sdo_oe_q, sdio_oe_q;

  spi_sync_edge #(.W(3), .STAGES(SYNC_STAGES), .INIT(3'b110)) u_sync (
    .clk (clk),
    .rst (rst),
    .din ({spi_csn, spi_sck, spi_sdio_i}),
    .dout(pins_s)
  );

  assign {csn_s, sck_s, sdi_s} = pins_s;

  always_ff @(posedge clk) begin
    if (rst) sck_prev <= 1'b1;
    else     sck_prev <= sck_s;
  end

  assign active = !csn_s;
  assign rise   = active && sck_s && !sck_prev;
  assign fall   = active && !sck_s && sck_prev;

  spi_bit_engine #(.DATA_W(DATA_W)) u_bits (
    .clk      (clk),
    .rst      (rst),
    .active   (active),
    .rise     (rise),
    .din      (sdi_s),
    .byte_done(byte_done),
    .byte_val (byte_val),
    .bit_idx  (bit_idx)
  );

  spi_txn_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .active   (active),
    .fall     (fall),
    .byte_done(byte_done),
    .byte_val (byte_val),
    .bit_idx  (bit_idx),
    .reg_rdata(reg_rdata),
    .rd_stb   (reg_rd_stb),
    .wr_stb   (reg_wr_stb),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .tx_bit   (tx_bit),
    .drive    (drive)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sdo_oe_q  <= 1'b0;
      sdio_oe_q <= 1'b0;
    end else begin
      sdo_oe_q  <= drive && active && !three_wire;
      sdio_oe_q <= drive && active && three_wire;
    end
  end

  assign spi_sdo_o   = tx_bit;
  assign spi_sdio_o  = tx_bit;
  assign spi_sdo_oe  = sdo_oe_q;
  assign spi_sdio_oe = sdio_oe_q;
endmodule

// File: rtl/spi_regslave_chk.sv
module spi_regslave_chk (
  input logic clk,
  input logic rst,
  input logic spi_csn,
  input logic spi_sdo_oe,
  input logic spi_sdio_oe,
  input logic reg_rd_stb,
  input logic reg_wr_stb
);
  // R11: strobes never overlap
  a_r11_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    !(reg_rd_stb && reg_wr_stb));

  // R11: write strobe lasts one cycle
  a_r11_wr_single: assert property (@(posedge clk) disable iff (rst)
    reg_wr_stb |=> !reg_wr_stb);

  // R11: read strobe lasts one cycle
  a_r11_rd_single: assert property (@(posedge clk) disable iff (rst)
    reg_rd_stb |=> !reg_rd_stb);

  // R7, R8: only one data pin is driven at a time
  a_r8_one_pin: assert property (@(posedge clk) disable iff (rst)
    !(spi_sdo_oe && spi_sdio_oe));

  // R9: pins released once chip select has been high for a while
  a_r9_idle_release: assert property (@(posedge clk) disable iff (rst)
    (spi_csn && $past(spi_csn) && $past(spi_csn, 2) && $past(spi_csn, 3)
     && $past(spi_csn, 4)) |-> (!spi_sdo_oe && !spi_sdio_oe));

  // R10: no register strobe while the interface is idle
  a_r10_idle_no_strobe: assert property (@(posedge clk) disable iff (rst)
    (spi_csn && $past(spi_csn) && $past(spi_csn, 2) && $past(spi_csn, 3)
     && $past(spi_csn, 4)) |-> (!reg_rd_stb && !reg_wr_stb));
endmodule

bind spi_regslave spi_regslave_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .spi_csn    (spi_csn),
  .spi_sdo_oe (spi_sdo_oe),
  .spi_sdio_oe(spi_sdio_oe),
  .reg_rd_stb (reg_rd_stb),
  .reg_wr_stb (reg_wr_stb)
);

// File: tb/tb_spi_regslave.sv
`timescale 1ns/1ps
module tb_spi_regslave;
  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       csn = 1'b1;
  logic       sck = 1'b1;
  logic       m_sdi = 1'b0;
  logic       mode3 = 1'b0;
  logic       sdio_i, sdio_o, sdio_oe, sdo_o, sdo_oe;
  logic       rd_stb, wr_stb;
  logic [5:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata = 8'h00;

  always #2 clk = ~clk;

  assign sdio_i = sdio_oe ? sdio_o : m_sdi;

  spi_regslave dut (
    .clk(clk), .rst(rst), .spi_csn(csn), .spi_sck(sck),
    .spi_sdio_i(sdio_i), .spi_sdio_o(sdio_o), .spi_sdio_oe(sdio_oe),
    .spi_sdo_o(sdo_o), .spi_sdo_oe(sdo_oe), .three_wire(mode3),
    .reg_rd_stb(rd_stb), .reg_wr_stb(wr_stb), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata)
  );

  // register bank model around the block
  logic [7:0] mem [64];
  logic [7:0] shadow [64];
  logic [5:0] wlog_a [512];
  logic [7:0] wlog_d [512];
  int wr_cnt = 0;
  int rd_cnt = 0;
  int overlap = 0;

  always @(posedge clk) begin
    if (rd_stb) begin
      rdata  <= mem[addr];
      rd_cnt <= rd_cnt + 1;
    end
    if (wr_stb) begin
      mem[addr]      <= wdata;
      wlog_a[wr_cnt] <= addr;
      wlog_d[wr_cnt] <= wdata;
      wr_cnt         <= wr_cnt + 1;
    end
    if (rd_stb && wr_stb) overlap <= overlap + 1;
  end

  int total = 0;
  int bad = 0;
  bit finished = 0;
  bit oe_bad;
  logic [7:0] tx_buf [8];
  logic [7:0] rx_buf [8];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] exp_addr(input logic [5:0] a, input bit inc, input int k);
    return inc ? 6'(a + 6'(k)) : a;
  endfunction

  task automatic send_byte(input logic [7:0] b, input bit listen, output logic [7:0] got);
    for (int i = 7; i >= 0; i--) begin
      sck = 1'b0;
      if (!listen) m_sdi = b[i];
      repeat (HALF) @(negedge clk);
      sck = 1'b1;
      got[i] = mode3 ? sdio_o : sdo_o;
      if (listen) begin
        if (!(mode3 ? (sdio_oe && !sdo_oe) : (sdo_oe && !sdio_oe))) oe_bad = 1'b1;
      end else if (sdo_oe || sdio_oe) begin
        oe_bad = 1'b1;
      end
      repeat (HALF) @(negedge clk);
    end
  endtask

  task automatic xfer(input bit rd, input bit inc, input logic [5:0] a, input int n);
    logic [7:0] g;
    oe_bad = 1'b0;
    @(negedge clk);
    csn = 1'b0;
    repeat (HALF) @(negedge clk);
    send_byte({rd, inc, a}, 1'b0, g);
    for (int k = 0; k < n; k++) begin
      send_byte(tx_buf[k], rd, g);
      rx_buf[k] = g;
    end
    csn = 1'b1;
    m_sdi = 1'b0;
    repeat (24) @(negedge clk);
  endtask

  task automatic do_write(input bit inc, input logic [5:0] a, input int n, input string req);
    int w0;
    bit ok;
    w0 = wr_cnt;
    xfer(1'b0, inc, a, n);
    check(wr_cnt - w0 == n, req, wr_cnt - w0, n);
    ok = 1'b1;
    for (int k = 0; k < n; k++) begin
      if (wlog_a[w0+k] !== exp_addr(a, inc, k) || wlog_d[w0+k] !== tx_buf[k]) ok = 1'b0;
      shadow[exp_addr(a, inc, k)] = tx_buf[k];
    end
    check(ok, req, int'(wlog_a[w0]), int'(a));
    check(!oe_bad, "R9 write oe", 1, 0);
  endtask

  task automatic do_read(input bit inc, input logic [5:0] a, input int n, input string req);
    int r0;
    int w0;
    logic [7:0] e;
    bit ok;
    r0 = rd_cnt;
    w0 = wr_cnt;
    xfer(1'b1, inc, a, n);
    check(rd_cnt - r0 == n + 1, "R6 strobe count", rd_cnt - r0, n + 1);
    check(wr_cnt == w0, "R11 no write on read", wr_cnt - w0, 0);
    ok = 1'b1;
    e = 8'h00;
    for (int k = 0; k < n; k++) begin
      if (rx_buf[k] !== shadow[exp_addr(a, inc, k)]) begin
        ok = 1'b0;
        e = shadow[exp_addr(a, inc, k)];
      end
    end
    check(ok, req, int'(rx_buf[0]), int'(e));
    check(!oe_bad, mode3 ? "R8 pin enable" : "R7 pin enable", 1, 0);
  endtask

  task automatic abort_after(input logic [7:0] cmd, input int nbits, input bit in_cmd);
    logic [7:0] g;
    int w0;
    w0 = wr_cnt;
    @(negedge clk);
    csn = 1'b0;
    repeat (HALF) @(negedge clk);
    if (!in_cmd) send_byte(cmd, 1'b0, g);
    for (int i = 0; i < nbits; i++) begin
      sck = 1'b0;
      m_sdi = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    csn = 1'b1;
    repeat (24) @(negedge clk);
    check(wr_cnt == w0, "R10 partial byte dropped", wr_cnt - w0, 0);
    check(!sdo_oe && !sdio_oe, "R9 idle after abort", int'({sdo_oe, sdio_oe}), 0);
  endtask

  initial begin
    int junk;
    junk = $urandom(32'h5EED);
    for (int i = 0; i < 64; i++) begin
      mem[i] = 8'h00;
      shadow[i] = 8'h00;
    end
    repeat (10) @(negedge clk);
    check(!sdo_oe && !sdio_oe && !rd_stb && !wr_stb, "R1 in reset",
          int'({sdo_oe, sdio_oe, rd_stb, wr_stb}), 0);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    check(!sdo_oe && !sdio_oe && !rd_stb && !wr_stb, "R1 after reset",
          int'({sdo_oe, sdio_oe, rd_stb, wr_stb}), 0);

    // R2 R3: single write, address 0x15
    tx_buf[0] = 8'hA5;
    do_write(1'b0, 6'h15, 1, "R3 single write");
    // R5 R7: single read back in four-wire mode
    do_read(1'b0, 6'h15, 1, "R5 single read");
    // R2: address with distinct high and low bits
    tx_buf[0] = 8'h3C;
    do_write(1'b0, 6'h2A, 1, "R2 address decode");
    do_read(1'b0, 6'h2A, 1, "R2 read decode");
    // R4: increment with wrap 62,63,0
    tx_buf[0] = 8'h11; tx_buf[1] = 8'h22; tx_buf[2] = 8'h33;
    do_write(1'b1, 6'd62, 3, "R4 increment wrap");
    // R4: fixed address
    tx_buf[0] = 8'h44; tx_buf[1] = 8'h55; tx_buf[2] = 8'h66;
    do_write(1'b0, 6'd5, 3, "R4 fixed address");
    check(mem[5] == 8'h66, "R4 last fixed write wins", int'(mem[5]), 8'h66);
    // R6: multi read, increment and fixed
    for (int i = 10; i < 14; i++) begin
      mem[i] = 8'($urandom);
      shadow[i] = mem[i];
    end
    do_read(1'b1, 6'd10, 4, "R6 increment read");
    do_read(1'b0, 6'd12, 3, "R6 fixed read");
    do_read(1'b1, 6'd63, 2, "R6 read wrap");
    // R8: three-wire mode
    mode3 = 1'b1;
    repeat (4) @(negedge clk);
    do_read(1'b1, 6'd10, 3, "R8 three-wire read");
    tx_buf[0] = 8'h9E; tx_buf[1] = 8'h01;
    do_write(1'b1, 6'd40, 2, "R8 three-wire write");
    do_read(1'b1, 6'd40, 2, "R8 three-wire readback");
    mode3 = 1'b0;
    repeat (4) @(negedge clk);
    // R10: aborts
    abort_after(8'h07, 5, 1'b0);
    abort_after(8'h00, 3, 1'b1);
    tx_buf[0] = 8'hC3;
    do_write(1'b0, 6'd7, 1, "R10 fresh command after abort");
    // random mix
    for (int t = 0; t < 24; t++) begin
      bit rd;
      bit inc;
      logic [5:0] a;
      int n;
      rd = 1'($urandom);
      inc = 1'($urandom);
      a = 6'($urandom);
      n = 1 + int'($urandom % 4);
      mode3 = 1'($urandom);
      repeat (2) @(negedge clk);
      for (int k = 0; k < n; k++) tx_buf[k] = 8'($urandom);
      if (rd) do_read(inc, a, n, "R6 random read");
      else    do_write(inc, a, n, "R4 random write");
    end
    check(overlap == 0, "R11 strobe overlap", overlap, 0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule